// File: doc/BRIEF.md
# Keyed Priority Command Register

This block is a small byte-wide register file through which a host asks for one of five maintenance commands. The host first sets one or more request bits in a mode register. It then writes a fixed key byte to a separate commit register. A commit picks the single highest-ranked pending request and announces it with a one-cycle pulse on that command's output line. In the following cycle the block throws away every other pending request and returns the commit register to zero. A commit write of any other byte does nothing.

The mode register also carries three bits that are not commands. The first is a power-up marker flag. The other two steer one general-purpose pad: a direction bit and a drive/readback bit. The pad is open-drain: the block only ever pulls it low or releases it. The pad level read back by the host passes through a small synchronizer first.

Host accesses use a valid/ready handshake. The block lowers `host_ready` for exactly one cycle, the completion cycle right after an accepted key write. No access completes in that cycle, so the host must hold its request until ready returns. In every other cycle the port accepts at once. Reads are combinational on `host_addr`.

Top module: `keyed_cmd_reg`

## Requirements
- R1: After reset the commit register (address 0x00) reads 0x00. The mode register (address 0x01) reads with bit 7 equal to `cfg_gpio_in_en`, bit 2 (power-up flag) equal to 1 and all command bits 0. Bit 6 reads 1 when the pad is an output and reads the pad level when it is an input.
- R2: An accepted write of 0xA9 to address 0x00 raises exactly one bit of `cmd_pulse` for exactly the one cycle after that write, when at least one command bit is set. The bits of `cmd_pulse` are [4]=mode bit 5, [3]=mode bit 4, [2]=mode bit 3, [1]=mode bit 1, [0]=mode bit 0.
- R3: The pulsed command is the highest-ranked set request, ranked by descending mode bit position (5, 4, 3, 1, 0). Mode bit 2 is never a command.
- R4: The commit register reads 0xA9 in the pulse cycle and 0x00 from the next cycle on. After the pulse cycle, mode bits 5, 4, 3, 1 and 0 read 0, and bits 7, 6 and 2 keep their values.
- R5: A write to address 0x00 of any byte other than 0xA9 gives no pulse, leaves the commit register at 0x00 and leaves the mode register unchanged.
- R6: A commit with no command bit set gives no pulse and still returns the commit register to 0x00.
- R7: A host write to mode bit 2 stores the written value and gives no pulse. A one-cycle `full_charge` clears the bit, and wins over a host write of 1 in the same cycle.
- R8: With mode bit 7 = 0, `gpio_oe` is 1 when bit 6 is 0 and 0 when bit 6 is 1. With bit 7 = 1, `gpio_oe` is 0 and bit 6 reads the pad level within three cycles of a pad change.
- R9: `host_ready` is 0 in the cycle after an accepted key write and 1 in all other cycles after reset.
- R10: Asserting reset clears all five command bits, so a later commit gives no pulse.
- R11: Writes to addresses other than 0x00 and 0x01 change nothing, and reads of such addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| host_valid | input | 1 | Host access request |
| host_ready | output | 1 | Block can accept the access this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| cfg_gpio_in_en | input | 1 | Reset value of the pad direction bit |
| full_charge | input | 1 | Event that clears the power-up flag |
| cmd_pulse | output | 5 | One-cycle command strobes, [4] highest rank |
| gpio_in | input | 1 | Pad level |
| gpio_oe | output | 1 | 1 = pull the pad low |

## Verification
The checker assumes that the host holds its request steady while `host_ready` is low. It also assumes that `full_charge` is a short event that has no ordering tie to commits. The bench only starts writes on falling edges at which the port is ready, and it waits out the completion cycle after every key write. So no access is ever offered in the stalled cycle. The pad input changes only between host accesses, and readback is sampled only after the synchronizer has had time to settle.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  // Mode register field positions; the neighbouring software decodes these.
  localparam int unsigned MB_IN_EN  = 7;
  localparam int unsigned MB_STATUS = 6;
  localparam int unsigned MB_PWRUP  = 2;
  localparam int unsigned NCMD      = 5;

  // Command index in the pulse vector: higher index ranks higher.
  typedef enum logic [2:0] {
    CMD_SLEEP   = 3'd0,
    CMD_HARD    = 3'd1,
    CMD_SOFT    = 3'd2,
    CMD_FULL    = 3'd3,
    CMD_LOADCAP = 3'd4
  } cmd_idx_e;

  // Mode-register bit position for each command index.
  function automatic int unsigned cmd_bitpos(input int unsigned idx);
    case (idx)
      0: return 0;
      1: return 1;
      2: return 3;
      3: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic logic [NCMD-1:0] cmds_of(input logic [7:0] b);
    logic [NCMD-1:0] c;
    for (int i = 0; i < NCMD; i++) c[i] = b[cmd_bitpos(i)];
    return c;
  endfunction

  function automatic logic [7:0] place_cmds(input logic [NCMD-1:0] c);
    logic [7:0] b;
    b = '0;
    for (int i = 0; i < NCMD; i++) b[cmd_bitpos(i)] = c[i];
    return b;
  endfunction
endpackage

// File: rtl/hcr_host_dec.sv
module hcr_host_dec #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 1,
  parameter logic [DATA_W-1:0] KEY       = 8'hA9
) (
  input  logic              valid,
  input  logic              ready,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ctrl_wr,
  output logic              mode_wr,
  output logic              key_hit,
  output logic              sel_ctrl,
  output logic              sel_mode
);
  logic accept_wr;

  assign sel_ctrl  = (addr == CTRL_ADDR);
  assign sel_mode  = (addr == MODE_ADDR);
  assign accept_wr = valid & ready & write;
  assign ctrl_wr   = accept_wr & sel_ctrl;
  assign mode_wr   = accept_wr & sel_mode;
  assign key_hit   = (wdata == KEY);
endmodule

// File: rtl/hcr_prio_pick.sv
module hcr_prio_pick #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  // above[i] = some request at index i or higher
  logic [N:0] above;
  assign above[N] = 1'b0;

  for (genvar i = N - 1; i >= 0; i--) begin : g_rank
    assign above[i] = above[i+1] | req[i];
    assign grant[i] = req[i] & ~above[i+1];
  end
endmodule

// File: rtl/hcr_gpio_cell.sv
module hcr_gpio_cell #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_en,
  input  logic drive,
  input  logic pad_in,
  output logic pad_oe,
  output logic level
);
  logic [SYNC_STAGES-1:0] sync_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q[s] <= 1'b1;
      end else if (s == 0) begin
        sync_q[s] <= pad_in;
      end else begin
        sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  // Open drain: only ever pull low.
  assign pad_oe = ~in_en & ~drive;
  assign level  = in_en ? sync_q[SYNC_STAGES-1] : drive;
endmodule

// File: rtl/keyed_cmd_reg.sv
module keyed_cmd_reg
  import hcr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h00,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h01,
  parameter logic [DATA_W-1:0] KEY       = 8'hA9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              cfg_gpio_in_en,
  input  logic              full_charge,
  output logic [NCMD-1:0]   cmd_pulse,
  input  logic              gpio_in,
  output logic              gpio_oe
);
  logic              busy_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [NCMD-1:0]   cmd_q;
  logic [NCMD-1:0]   pulse_q;
  logic              in_en_q, drive_q, pwrup_q;
  logic              ctrl_wr, mode_wr, key_hit, sel_ctrl, sel_mode;
  logic [NCMD-1:0]   grant;
  logic              pad_level;
  logic [7:0]        mode_view;

  assign host_ready = ~busy_q;

  hcr_host_dec #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTRL_ADDR(CTRL_ADDR), .MODE_ADDR(MODE_ADDR), .KEY(KEY)
  ) u_dec (
    .valid(host_valid), .ready(host_ready), .write(host_write),
    .addr(host_addr), .wdata(host_wdata),
    .ctrl_wr(ctrl_wr), .mode_wr(mode_wr), .key_hit(key_hit),
    .sel_ctrl(sel_ctrl), .sel_mode(sel_mode)
  );

  hcr_prio_pick #(.N(NCMD)) u_pick (.req(cmd_q), .grant(grant));

  hcr_gpio_cell #(.SYNC_STAGES(SYNC_STAGES)) u_gpio (
    .clk(clk), .rst_n(rst_n), .in_en(in_en_q), .drive(drive_q),
    .pad_in(gpio_in), .pad_oe(gpio_oe), .level(pad_level)
  );

  // Commit sequencing: key write -> pulse cycle -> cleared.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ctrl_q  <= '0;
      pulse_q <= '0;
    end else if (busy_q) begin
      busy_q  <= 1'b0;
      ctrl_q  <= '0;
      pulse_q <= '0;
    end else if (ctrl_wr && key_hit) begin
      busy_q  <= 1'b1;
      ctrl_q  <= KEY;
      pulse_q <= grant;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (busy_q) begin
      cmd_q <= '0;
    end else if (mode_wr) begin
      cmd_q <= cmds_of(host_wdata[7:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_en_q <= cfg_gpio_in_en;
      drive_q <= 1'b1;
      pwrup_q <= 1'b1;
    end else begin
      if (mode_wr) begin
        in_en_q <= host_wdata[MB_IN_EN];
        drive_q <= host_wdata[MB_STATUS];
        pwrup_q <= host_wdata[MB_PWRUP];
      end
      if (full_charge) pwrup_q <= 1'b0;
    end
  end

  always_comb begin
    mode_view            = place_cmds(cmd_q);
    mode_view[MB_IN_EN]  = in_en_q;
    mode_view[MB_STATUS] = pad_level;
    mode_view[MB_PWRUP]  = pwrup_q;
  end

  always_comb begin
    host_rdata = '0;
    if (sel_ctrl)      host_rdata = ctrl_q;
    else if (sel_mode) host_rdata = DATA_W'(mode_view);
  end

  assign cmd_pulse = pulse_q;
endmodule

// File: rtl/keyed_cmd_reg_chk.sv
module keyed_cmd_reg_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NCMD   = 5,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h00,
  parameter logic [DATA_W-1:0] KEY       = 8'hA9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_valid,
  input logic              host_ready,
  input logic              host_write,
  input logic [ADDR_W-1:0] host_addr,
  input logic [DATA_W-1:0] host_wdata,
  input logic [NCMD-1:0]   cmd_pulse,
  input logic [NCMD-1:0]   cmd_q,
  input logic [DATA_W-1:0] ctrl_q
);
  logic ctrl_acc, key_acc;
  assign ctrl_acc = host_valid && host_ready && host_write && (host_addr == CTRL_ADDR);
  assign key_acc  = ctrl_acc && (host_wdata == KEY);

  // R2
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_pulse));
  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_pulse) |=> (cmd_pulse == '0));
  // R2
  pulse_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_acc |=> ((|cmd_pulse) == $past(|cmd_q)));
  // R3
  top_rank_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_acc && cmd_q[NCMD-1]) |=> cmd_pulse[NCMD-1]);
  // R4
  clear_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ready |=> (ctrl_q == '0 && cmd_q == '0));
  // R4
  key_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_acc |=> (ctrl_q == KEY));
  // R5
  bad_key_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_acc && host_wdata != KEY) |=> (cmd_pulse == '0 && ctrl_q == '0));
  // R6
  empty_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_acc && cmd_q == '0) |=> (cmd_pulse == '0));
  // R9
  stall_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_acc |=> !host_ready);
  // R9
  stall_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ready |=> host_ready);
endmodule

bind keyed_cmd_reg keyed_cmd_reg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCMD(hcr_pkg::NCMD),
  .CTRL_ADDR(CTRL_ADDR), .KEY(KEY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
  .host_write(host_write), .host_addr(host_addr), .host_wdata(host_wdata),
  .cmd_pulse(cmd_pulse), .cmd_q(cmd_q), .ctrl_q(ctrl_q)
);

// File: tb/keyed_cmd_reg_tb.sv
module keyed_cmd_reg_tb;
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_MODE = 8'h01;
  localparam logic [7:0] KEYV   = 8'hA9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_valid = 1'b0, host_write = 1'b0;
  logic [7:0] host_addr = 8'h00, host_wdata = 8'h00;
  logic       host_ready;
  logic [7:0] host_rdata;
  logic       cfg_gpio_in_en = 1'b1, full_charge = 1'b0, gpio_in = 1'b1;
  logic [4:0] cmd_pulse;
  logic       gpio_oe;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  keyed_cmd_reg u_dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .cfg_gpio_in_en(cfg_gpio_in_en),
    .full_charge(full_charge), .cmd_pulse(cmd_pulse),
    .gpio_in(gpio_in), .gpio_oe(gpio_oe)
  );

  // {mode byte, commit byte, expected pulse, expected mode after}
  localparam int NV = 11;
  localparam logic [28:0] VEC [NV] = '{
    {8'h7F, 8'hA9, 5'b10000, 8'h44},
    {8'h5F, 8'hA9, 5'b01000, 8'h44},
    {8'h4F, 8'hA9, 5'b00100, 8'h44},
    {8'h43, 8'hA9, 5'b00010, 8'h40},
    {8'h41, 8'hA9, 5'b00001, 8'h40},
    {8'h44, 8'hA9, 5'b00000, 8'h44},
    {8'h6A, 8'hA9, 5'b10000, 8'h40},
    {8'h53, 8'hA9, 5'b01000, 8'h40},
    {8'h49, 8'hA9, 5'b00100, 8'h40},
    {8'h7F, 8'hA8, 5'b00000, 8'h7F},
    {8'h5B, 8'h00, 5'b00000, 8'h5B}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #100us;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state, pad as input (cfg=1, pad high)
    bus_rd(A_CTRL, rd); check("R1 ctrl", rd, 8'h00);
    bus_rd(A_MODE, rd); check("R1 mode cfg1", rd, 8'hC4);
    check("R1 oe", gpio_oe, 1'b0);
    check("R9 ready idle", host_ready, 1'b1);

    // R2 R3 R4 R5 R6 table
    for (int i = 0; i < NV; i++) begin
      logic [7:0] m, c, aft;
      logic [4:0] p;
      {m, c, p, aft} = VEC[i];
      bus_wr(A_MODE, m);
      bus_wr(A_CTRL, c);
      check("R2/R3 pulse", cmd_pulse, p);
      if (c == KEYV) begin
        bus_rd(A_CTRL, rd); check("R4 key visible", rd, KEYV);
        check("R9 stalled", host_ready, 1'b0);
      end
      @(negedge clk);
      check("R2 pulse gone", cmd_pulse, 5'b0);
      check("R9 ready back", host_ready, 1'b1);
      bus_rd(A_CTRL, rd); check("R4/R5/R6 ctrl cleared", rd, 8'h00);
      bus_rd(A_MODE, rd); check("R4/R5 mode after", rd, aft);
    end

    // R7 power-up flag
    bus_wr(A_MODE, 8'h40);
    bus_rd(A_MODE, rd); check("R7 host clear", rd, 8'h40);
    bus_wr(A_MODE, 8'h44);
    check("R7 set no pulse", cmd_pulse, 5'b0);
    bus_rd(A_MODE, rd); check("R7 host set", rd, 8'h44);
    @(negedge clk); full_charge = 1'b1;
    @(negedge clk); full_charge = 1'b0;
    bus_rd(A_MODE, rd); check("R7 full charge", rd, 8'h40);
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_addr = A_MODE; host_wdata = 8'h44;
    full_charge = 1'b1;
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0; full_charge = 1'b0;
    bus_rd(A_MODE, rd); check("R7 charge wins", rd, 8'h40);

    // R8 pad control
    bus_wr(A_MODE, 8'h00);
    check("R8 drive low", gpio_oe, 1'b1);
    bus_rd(A_MODE, rd); check("R8 read drive", rd, 8'h00);
    bus_wr(A_MODE, 8'h40);
    check("R8 release", gpio_oe, 1'b0);
    bus_wr(A_MODE, 8'h80);
    check("R8 input no drive", gpio_oe, 1'b0);
    gpio_in = 1'b0;
    repeat (3) @(negedge clk);
    bus_rd(A_MODE, rd); check("R8 sense low", rd, 8'h80);
    gpio_in = 1'b1;
    repeat (3) @(negedge clk);
    bus_rd(A_MODE, rd); check("R8 sense high", rd, 8'hC0);

    // R11 unmapped address
    bus_wr(A_MODE, 8'h44);
    bus_wr(8'h07, 8'hFF);
    bus_rd(8'h07, rd); check("R11 unmapped read", rd, 8'h00);
    bus_rd(A_MODE, rd); check("R11 mode untouched", rd, 8'h44);
    check("R11 no pulse", cmd_pulse, 5'b0);

    // R10 reset drops pending commands; R1 with cfg=0
    bus_wr(A_MODE, 8'h7B);
    cfg_gpio_in_en = 1'b0;
    do_reset();
    bus_rd(A_MODE, rd); check("R10/R1 mode after reset", rd, 8'h44);
    check("R1 oe cfg0", gpio_oe, 1'b0);
    bus_wr(A_CTRL, KEYV);
    check("R10 no pulse", cmd_pulse, 5'b0);
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule